// File: doc/BRIEF.md
# Randomized Two-Rule Competition Stage

This block is a transition engine for a membrane system with one object type, `a`, that feeds two competing rules. The first rule keeps its `a` and emits one `b'`. The second rule consumes its `a` and emits one `b'`. On every clock where stepping is enabled, the block applies both rules in a maximally parallel way. A pseudo-random word splits the current count of `a` into a keep share and a drop share. The first rule fires once for each copy in the keep share, and the second rule fires once for each copy in the drop share. The new counts of `a` and `b'` are written back in that same cycle.

A run starts with a one-cycle load strobe. The strobe sets the initial count of `a`, clears the `b'` count and seeds the generator. After that, every clock with the step enable high performs one complete transition. The count of `a` strictly shrinks on every transition, so a run always reaches zero. When it does, the halted flag rises and the block freezes until the next load or reset. All pins are plain control and status pins: the block has no streamed data, so there is no back-pressure. A step request is simply ignored while the block is halted.

Top module: `rule_compete_stage`

## Requirements
- R1: After reset the `a` count and the `b'` count are 0 and `halted_o` is 1.
- R2: A cycle with `load_i` high sets the `a` count to `load_count_i` and the `b'` count to 0, and loads the generator from `seed_i`. A load takes priority over a step requested in the same cycle.
- R3: A seed of 0 is replaced by 1, so the generator word is never zero.
- R4: The generator word R is 16 bits wide. It is used as loaded for the first transition after a load. After each applied transition it advances to `{R[14:0], R[15]^R[14]^R[12]^R[3]}`, the maximal-length polynomial with taps 16, 15, 13 and 4.
- R5: In an applied transition, the keep share is `floor(a*R/65536)` and the drop share is `a - keep`. The new `a` count equals the keep share.
- R6: In an applied transition, the `b'` count grows by keep + drop, which is the old `a` count. It saturates at 65535.
- R7: A cycle with `step_en_i` low and `load_i` low changes neither count.
- R8: `halted_o` is 1 exactly when the `a` count is 0. While halted, a step request changes neither count.
- R9: Each enabled clock applies one full transition, and back-to-back enabled clocks apply one transition each with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_i | input | 16 | Generator seed, taken on load |
| load_i | input | 1 | One-cycle load strobe for a new run |
| load_count_i | input | 16 | Initial `a` count, taken on load |
| step_en_i | input | 1 | Apply one transition this clock |
| count_a_o | output | 16 | Current multiplicity of `a` |
| count_b_o | output | 16 | Current multiplicity of `b'` (saturating) |
| halted_o | output | 1 | High when no `a` remains |

## Verification
The bench loads seed 0 to check the lock-up guard. A design that keeps the zero would freeze the generator, and its nonzero assertion would fire. A maximum count combined with an all-ones seed pushes `b'` past 65535 within two steps. A design that wrapped instead of saturating would show a small `b'` count. Loads are raised together with a step request to expose a wrong priority, and the bench keeps stepping after the halt to catch a block that keeps moving. Random runs with sparse enables and back-to-back steps compare each cycle against a bench model of the split and the polynomial. A wrong tap or a wrong product slice then shows up as a diverging `a` count within a few steps.

// File: rtl/rule_compete_pkg.sv
package rule_compete_pkg;
  localparam int CNT_W = 16;
  localparam logic [CNT_W-1:0] POLY_MASK = 16'hD008;
  typedef logic [CNT_W-1:0] count_t;
endpackage

// File: rtl/compete_lfsr.sv
module compete_lfsr #(
  parameter int W = rule_compete_pkg::CNT_W,
  parameter logic [W-1:0] TAPS = rule_compete_pkg::POLY_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] seed_i,
  input  logic         load_i,
  input  logic         adv_i,
  output logic [W-1:0] word_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] word_q;
  logic [W-1:0] seed_fix;
  logic         fb;

  assign seed_fix = (seed_i == '0) ? ONE : seed_i;
  assign fb       = ^(word_q & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= ONE;
    else if (load_i) word_q <= seed_fix;
    else if (adv_i)  word_q <= {word_q[W-2:0], fb};
  end

  assign word_o = word_q;

  // R3: the generator never holds the all-zero lock-up word
  assert_word_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_q != '0);

  // R4: the word holds still unless advanced or reloaded
  assert_word_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(word_q));
endmodule

// File: rtl/compete_split.sv
module compete_split #(
  parameter int W = rule_compete_pkg::CNT_W
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] rnd_i,
  output logic [W-1:0] keep_o,
  output logic [W-1:0] drop_o
);
  localparam int PW = 2 * W;

  logic [PW-1:0] prod;

  assign prod   = {{W{1'b0}}, cnt_i} * {{W{1'b0}}, rnd_i};
  assign keep_o = prod[PW-1:W];
  assign drop_o = cnt_i - keep_o;
endmodule

// File: rtl/compete_sat_add.sv
module compete_sat_add #(
  parameter int W = rule_compete_pkg::CNT_W
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] inc_i,
  output logic [W-1:0] sum_o
);
  logic [W:0] wide;

  assign wide  = {1'b0, base_i} + {1'b0, inc_i};
  assign sum_o = wide[W] ? {W{1'b1}} : wide[W-1:0];
endmodule

// File: rtl/rule_compete_stage.sv
module rule_compete_stage #(
  parameter int W = rule_compete_pkg::CNT_W,
  parameter logic [W-1:0] TAPS = rule_compete_pkg::POLY_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] seed_i,
  input  logic         load_i,
  input  logic [W-1:0] load_count_i,
  input  logic         step_en_i,
  output logic [W-1:0] count_a_o,
  output logic [W-1:0] count_b_o,
  output logic         halted_o
);
  logic [W-1:0] a_q, b_q;
  logic [W-1:0] rnd, keep, drop, applied, b_next;
  logic         fire;

  assign fire = step_en_i && !load_i && (a_q != '0);

  compete_lfsr #(.W(W), .TAPS(TAPS)) lfsr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .seed_i (seed_i),
    .load_i (load_i),
    .adv_i  (fire),
    .word_o (rnd)
  );

  compete_split #(.W(W)) split_i (
    .cnt_i  (a_q),
    .rnd_i  (rnd),
    .keep_o (keep),
    .drop_o (drop)
  );

  // every copy of a fires exactly one rule, each emitting one b'
  assign applied = keep + drop;

  compete_sat_add #(.W(W)) sat_i (
    .base_i (b_q),
    .inc_i  (applied),
    .sum_o  (b_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load_i) begin
      a_q <= load_count_i;
      b_q <= '0;
    end else if (fire) begin
      a_q <= keep;
      b_q <= b_next;
    end
  end

  assign count_a_o = a_q;
  assign count_b_o = b_q;
  assign halted_o  = (a_q == '0);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (count_a_o == $past(load_count_i)) && (count_b_o == '0));

  assert_a_shrinks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en_i && !load_i && !halted_o) |=> count_a_o < $past(count_a_o));

  assert_b_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> count_b_o >= $past(count_b_o));

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en_i && !load_i) |=> $stable(count_a_o) && $stable(count_b_o));

  assert_halt_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o && !load_i) |=> halted_o && $stable(count_b_o));
endmodule

// File: tb/rule_compete_stage_tb_top.sv
module rule_compete_stage_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] seed_i = '0;
  logic        load_i = 1'b0;
  logic [15:0] load_count_i = '0;
  logic        step_en_i = 1'b0;
  logic [15:0] count_a_o, count_b_o;
  logic        halted_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  logic [15:0] m_a = '0, m_b = '0, m_r = 16'd1;

  always #5 clk = ~clk;

  rule_compete_stage dut_i (
    .clk(clk), .rst_n(rst_n), .seed_i(seed_i), .load_i(load_i),
    .load_count_i(load_count_i), .step_en_i(step_en_i),
    .count_a_o(count_a_o), .count_b_o(count_b_o), .halted_o(halted_o)
  );

  function automatic logic [15:0] poly_next(logic [15:0] q);
    return {q[14:0], q[15] ^ q[14] ^ q[12] ^ q[3]};
  endfunction

  function automatic logic [15:0] keep_share(logic [15:0] a, logic [15:0] r);
    logic [31:0] p;
    p = 32'(a) * 32'(r);
    return p[31:16];
  endfunction

  function automatic logic [15:0] sat16(logic [15:0] x, logic [15:0] y);
    int unsigned s;
    s = int'(x) + int'(y);
    return (s > 65535) ? 16'hFFFF : s[15:0];
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cycles);
      finish_run();
    end
  end

  task automatic check_state(string tag);
    checks++;
    if (count_a_o !== m_a || count_b_o !== m_b || halted_o !== (m_a == 0)) begin
      fails++;
      $display("FAIL %s: actual a=%0d b=%0d halted=%0d expected a=%0d b=%0d halted=%0d",
               tag, count_a_o, count_b_o, halted_o, m_a, m_b, (m_a == 0));
    end
  endtask

  // one clock: drive at negedge, advance model, compare at next negedge
  task automatic cyc(bit ld, logic [15:0] cnt, logic [15:0] sd, bit en, string tag);
    string t;
    load_i = ld; load_count_i = cnt; seed_i = sd; step_en_i = en;
    @(posedge clk);
    @(negedge clk);
    t = tag;
    if (ld) begin
      m_a = cnt; m_b = 16'd0; m_r = (sd == 0) ? 16'd1 : sd;
      if (t == "") t = "R2";
    end else if (m_a == 0) begin
      if (t == "") t = "R8";
    end else if (!en) begin
      if (t == "") t = "R7";
    end else begin
      if (t == "") t = (32'(m_b) + 32'(m_a) > 65535) ? "R6" : "R5";
      m_b = sat16(m_b, m_a);
      m_a = keep_share(m_a, m_r);
      m_r = poly_next(m_r);
    end
    check_state(t);
    load_i = 0; step_en_i = 0;
  endtask

  initial begin
    int unsigned s0;
    s0 = $urandom(32'd20160201);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 reset");

    // R8: stepping while halted straight after reset
    cyc(0, 0, 0, 1, "R8 halted step");

    // R3: zero seed behaves as seed 1
    cyc(1, 16'd100, 16'd0, 0, "R3 load");
    cyc(0, 0, 0, 1, "R3 step with replaced seed");
    cyc(0, 0, 0, 1, "R8 step after halt");

    // R2: load wins over a simultaneous step
    cyc(1, 16'd5000, 16'h1234, 1, "R2 load priority");
    cyc(1, 16'd4000, 16'h4321, 1, "R2 reload priority");

    // R4 R9: back-to-back steps follow the polynomial sequence
    cyc(1, 16'd40000, 16'hACE1, 0, "R4 load");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, "R4 R9 consecutive step");
    cyc(0, 0, 0, 0, "R7 idle");
    cyc(0, 0, 0, 0, "R7 idle");
    cyc(0, 0, 0, 1, "R9 resume");

    // R6: saturation of b'
    cyc(1, 16'hFFFF, 16'hFFFF, 0, "R6 load");
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, "R6 saturating step");
    while (m_a != 0) cyc(0, 0, 0, 1, "R6 run to halt");
    cyc(0, 0, 0, 1, "R8 frozen after run");

    // random runs
    for (int run = 0; run < 60; run++) begin
      logic [15:0] c, sd;
      c  = ($urandom % 4 == 0) ? 16'($urandom % 8) : 16'($urandom);
      sd = ($urandom % 8 == 0) ? 16'd0 : 16'($urandom);
      cyc(1, c, sd, $urandom % 2 == 1, "");
      for (int k = 0; k < 40; k++) begin
        if ($urandom % 50 == 0)
          cyc(1, 16'($urandom), 16'($urandom), 1, "");
        else
          cyc(0, 0, 0, ($urandom % 10) < 7, "");
      end
    end
    finish_run();
  end
endmodule